// File: doc/BRIEF.md
# DDR SDRAM Command Monitor

This block sits beside a four-bank DDR SDRAM control bus and looks at the pins once per clock. The pins are the previous and current clock enable, chip select, the three strobes (RAS, CAS, WE), the bank bits and the A10 line. From these it names the command on the bus and reports it as a one-hot code, together with the addressed bank and the auto-precharge/all-banks qualifier. All outputs are registered, so the report for the pins present before clock edge k is shown from edge k on.

Alongside the decode, the block keeps a model of the device. The model holds which banks have an open row and which power state the device is in (running, precharge power-down, active power-down, self-refresh). It also holds two wait windows: one after a mode-register write, and one while a write burst with auto-precharge is still running. The violation output goes high for one cycle when the command just reported was illegal in that state. A command that is flagged leaves the model untouched. The block is meant for assertion-style checking of a memory controller in simulation or in silicon debug logic.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With clock enable high on both cycles and chip select low, the strobe levels {RAS,CAS,WE} decode as follows: 000 mode-register write, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge. The code bits of `cmd_o` are: 0 no-op, 1 mode write, 2 extended mode write, 3 refresh, 4 self-refresh entry, 5 self-refresh exit, 6 activate, 7 read, 8 write, 9 burst stop, 10 precharge, 11 power-down entry, 12 power-down exit, 13 clock-enable error. Exactly one bit is set, and it appears one cycle after the pins.
- R2: Chip select high, or strobes 111, gives the no-op code. With clock enable low on both cycles, the pins give the no-op code and are otherwise ignored.
- R3: `bank_o` repeats the bank bits, with bit 0 as the LSB. `ap_o` repeats A10 for read, write and precharge and is 0 otherwise. A mode write with bank bit 0 set is reported as the extended mode write (code bit 2).
- R4: Clock enable falling with a no-op encoding enters power-down: `pwr_o`=2 (active) if a bank is open, else 1 (precharge). Falling with the refresh encoding enters self-refresh (`pwr_o`=3). Rising gives the self-refresh exit code when in self-refresh, otherwise the power-down exit code, and `pwr_o` returns to 0.
- R5: Activate sets `open_o[bank]`. Precharge with A10 low clears only the addressed bank. Precharge with A10 high clears every bank and ignores the bank bits.
- R6: A read with A10 high closes its bank, and `open_o` shows this in the same report cycle.
- R7: After a write with A10 high, a read or write in any of the next BURST_LEN/2 cycles is a violation. The written bank closes together with the report of the last of those cycles.
- R8: Mode write, extended mode write, refresh or self-refresh entry issued while any bank is open is a violation.
- R9: A command whose code is not no-op, in either of the 2 cycles after an accepted mode write or extended mode write, is a violation.
- R10: Activating a bank that is open, or reading or writing a bank that is closed, is a violation.
- R11: Clock enable falling with any encoding other than no-op or refresh gives code bit 13 and a violation.
- R12: A violating command changes neither `open_o`, `pwr_o` nor any wait window. `viol_o` is high only in the report of the violating command.
- R13: During reset: `cmd_o` shows no-op, `viol_o`=0, `open_o`=0, `pwr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_prev_i | input | 1 | Clock enable sampled on the previous cycle |
| cke_i | input | 1 | Clock enable on this cycle |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank select bits |
| a10_i | input | 1 | Auto-precharge / all-banks line |
| cmd_o | output | 14 | One-hot command code |
| bank_o | output | BANK_W | Registered bank bits |
| ap_o | output | 1 | Auto-precharge or all-banks qualifier |
| viol_o | output | 1 | One-cycle illegal-command pulse |
| open_o | output | 2**BANK_W | Open-row flag per bank |
| pwr_o | output | 2 | Power state: 0 run, 1 precharge PD, 2 active PD, 3 self-refresh |

## Verification
A wrong bank model shows up on `open_o` in the very report of the command that corrupted it. The next activate, read or refresh to that bank then raises or drops `viol_o` wrongly. A stuck or miscounted wait window cannot be seen directly: it shows only when a read, write or non-no-op command lands inside or just after the window, as a wrong `viol_o` on that cycle. Random traffic mixed with back-to-back directed commands at the window edges exposes it within a few cycles.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
    localparam int CMD_W = 14;

    typedef enum logic [3:0] {
        C_NOP      = 4'd0,
        C_MRS      = 4'd1,
        C_EMRS     = 4'd2,
        C_REF      = 4'd3,
        C_SREF_IN  = 4'd4,
        C_SREF_OUT = 4'd5,
        C_ACT      = 4'd6,
        C_RD       = 4'd7,
        C_WR       = 4'd8,
        C_BST      = 4'd9,
        C_PRE      = 4'd10,
        C_PD_IN    = 4'd11,
        C_PD_OUT   = 4'd12,
        C_CKE_ERR  = 4'd13
    } cmd_e;

    typedef enum logic [1:0] {
        PW_RUN  = 2'd0,
        PW_PPD  = 2'd1,
        PW_APD  = 2'd2,
        PW_SREF = 2'd3
    } pwr_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic ba0_i,
    input  logic in_sref_i,
    output cmd_e cmd_o
);
    logic [2:0] strobes;
    logic       quiet;

    always_comb begin
        strobes = {ras_n_i, cas_n_i, we_n_i};
        quiet   = cs_n_i || (strobes == 3'b111);
        cmd_o   = C_NOP;
        case ({cke_prev_i, cke_i})
            2'b00: cmd_o = C_NOP;
            2'b01: cmd_o = in_sref_i ? C_SREF_OUT : C_PD_OUT;
            2'b10: begin
                if (quiet)                   cmd_o = C_PD_IN;
                else if (strobes == 3'b001)  cmd_o = C_SREF_IN;
                else                         cmd_o = C_CKE_ERR;
            end
            default: begin
                if (!quiet) begin
                    case (strobes)
                        3'b000:  cmd_o = ba0_i ? C_EMRS : C_MRS;
                        3'b001:  cmd_o = C_REF;
                        3'b011:  cmd_o = C_ACT;
                        3'b101:  cmd_o = C_RD;
                        3'b100:  cmd_o = C_WR;
                        3'b110:  cmd_o = C_BST;
                        3'b010:  cmd_o = C_PRE;
                        default: cmd_o = C_NOP;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/ddr_rule_check.sv
module ddr_rule_check
    import ddr_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  cmd_e              cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [NB-1:0]     open_i,
    input  logic              mrs_busy_i,
    input  logic              wap_busy_i,
    output logic              viol_o
);
    logic any_open;
    logic tgt_open;

    always_comb begin
        any_open = |open_i;
        tgt_open = open_i[bank_i];
        viol_o   = 1'b0;
        if (mrs_busy_i && (cmd_i != C_NOP)) viol_o = 1'b1;
        case (cmd_i)
            C_MRS, C_EMRS, C_REF, C_SREF_IN: if (any_open) viol_o = 1'b1;
            C_ACT:       if (tgt_open) viol_o = 1'b1;
            C_RD, C_WR:  if (!tgt_open || wap_busy_i) viol_o = 1'b1;
            C_CKE_ERR:   viol_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_bank_next.sv
module ddr_bank_next
    import ddr_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  logic [NB-1:0]     open_q_i,
    input  cmd_e              cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              a10_i,
    input  logic              viol_i,
    input  logic              wap_done_i,
    input  logic [BANK_W-1:0] wap_bank_i,
    output logic [NB-1:0]     open_d_o
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        logic nxt;
        assign hit = (bank_i == BANK_W'(b));
        always_comb begin
            nxt = open_q_i[b];
            if (wap_done_i && (wap_bank_i == BANK_W'(b))) nxt = 1'b0;
            if (!viol_i) begin
                case (cmd_i)
                    C_ACT:   if (hit) nxt = 1'b1;
                    C_PRE:   if (a10_i || hit) nxt = 1'b0;
                    C_RD:    if (a10_i && hit) nxt = 1'b0;
                    default: ;
                endcase
            end
        end
        assign open_d_o[b] = nxt;
    end
endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int MRS_GAP   = 2,
    localparam int NB       = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_prev_i,
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic              a10_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ap_o,
    output logic              viol_o,
    output logic [NB-1:0]     open_o,
    output logic [1:0]        pwr_o
);
    localparam int WAP_CYC = BURST_LEN / 2;
    localparam int MW      = $clog2(MRS_GAP + 1);
    localparam int WW      = $clog2(WAP_CYC + 1);

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic              ap;
        logic              viol;
        logic [NB-1:0]     open;
        pwr_e              pwr;
        logic [MW-1:0]     mrs_cnt;
        logic [WW-1:0]     wap_cnt;
        logic [BANK_W-1:0] wap_bank;
    } mon_state_t;

    mon_state_t st_d, st_q;
    cmd_e          cmd_now;
    logic          viol_now;
    logic          wap_done;
    logic [NB-1:0] open_nxt;

    ddr_cmd_decode u_decode (
        .cke_prev_i (cke_prev_i),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .ba0_i      (ba_i[0]),
        .in_sref_i  (st_q.pwr == PW_SREF),
        .cmd_o      (cmd_now)
    );

    ddr_rule_check #(.BANK_W(BANK_W)) u_rules (
        .cmd_i      (cmd_now),
        .bank_i     (ba_i),
        .open_i     (st_q.open),
        .mrs_busy_i (st_q.mrs_cnt != '0),
        .wap_busy_i (st_q.wap_cnt != '0),
        .viol_o     (viol_now)
    );

    assign wap_done = (st_q.wap_cnt == WW'(1));

    ddr_bank_next #(.BANK_W(BANK_W)) u_banks (
        .open_q_i   (st_q.open),
        .cmd_i      (cmd_now),
        .bank_i     (ba_i),
        .a10_i      (a10_i),
        .viol_i     (viol_now),
        .wap_done_i (wap_done),
        .wap_bank_i (st_q.wap_bank),
        .open_d_o   (open_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = cmd_now;
        st_d.bank = ba_i;
        st_d.ap   = a10_i && ((cmd_now == C_RD) || (cmd_now == C_WR) || (cmd_now == C_PRE));
        st_d.viol = viol_now;
        st_d.open = open_nxt;
        if (st_q.mrs_cnt != '0) st_d.mrs_cnt = st_q.mrs_cnt - 1'b1;
        if (st_q.wap_cnt != '0) st_d.wap_cnt = st_q.wap_cnt - 1'b1;
        if (!viol_now) begin
            case (cmd_now)
                C_MRS, C_EMRS: st_d.mrs_cnt = MW'(MRS_GAP);
                C_WR: begin
                    if (a10_i) begin
                        st_d.wap_cnt  = WW'(WAP_CYC);
                        st_d.wap_bank = ba_i;
                    end
                end
                C_SREF_IN:             st_d.pwr = PW_SREF;
                C_PD_IN:               st_d.pwr = (|st_q.open) ? PW_APD : PW_PPD;
                C_SREF_OUT, C_PD_OUT:  st_d.pwr = PW_RUN;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: C_NOP, bank: '0, ap: 1'b0, viol: 1'b0, open: '0,
                      pwr: PW_RUN, mrs_cnt: '0, wap_cnt: '0, wap_bank: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o  = CMD_W'(1) << st_q.cmd;
    assign bank_o = st_q.bank;
    assign ap_o   = st_q.ap;
    assign viol_o = st_q.viol;
    assign open_o = st_q.open;
    assign pwr_o  = st_q.pwr;
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CMD_W-1:0]  cmd_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              ap_o,
    input logic              viol_o,
    input logic [NB-1:0]     open_o,
    input logic [1:0]        pwr_o
);
    AST_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_o) == 1); // R1

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_ACT] && !viol_o) |-> open_o[bank_o]); // R5

    AST_PRE_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_PRE] && ap_o && !viol_o) |-> (open_o == '0)); // R5

    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o[C_MRS] || cmd_o[C_EMRS] || cmd_o[C_REF] || cmd_o[C_SREF_IN]) && !viol_o)
        |-> (open_o == '0)); // R8

    AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o[C_MRS] || cmd_o[C_EMRS]) && !viol_o) |=> (cmd_o[C_NOP] || viol_o)); // R9

    AST_SREF_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_SREF_IN] && !viol_o) |-> (pwr_o == 2'd3)); // R4

    AST_CKE_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[C_CKE_ERR] |-> viol_o); // R11
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;
    localparam int BL = 4;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [13:0] cmd_o;
    logic [1:0] bank_o, pwr_o;
    logic ap_o, viol_o;
    logic [3:0] open_o;

    int n_cmp = 0, n_bad = 0;
    bit [3:0] m_open = 4'd0;
    int m_pwr = 0, m_mrs = 0, m_wap = 0, m_wapb = 0;
    bit cur_cke = 1'b1;

    always #5 clk = ~clk;

    ddr_cmd_monitor #(.BANK_W(2), .BURST_LEN(BL), .MRS_GAP(GAP)) u_ddr_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cke_prev_i(cke_prev), .cke_i(cke), .cs_n_i(cs_n),
        .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .a10_i(a10),
        .cmd_o(cmd_o), .bank_o(bank_o), .ap_o(ap_o), .viol_o(viol_o),
        .open_o(open_o), .pwr_o(pwr_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_code(bit cp, bit ck, bit cs, bit r, bit c, bit w, bit b0, bit in_sref);
        bit quiet;
        quiet = cs || (r && c && w);
        if (!cp) return ck ? (in_sref ? 5 : 12) : 0;
        if (!ck) begin
            if (quiet) return 11;
            if (!r && !c && w) return 4;
            return 13;
        end
        if (quiet) return 0;
        if (!r && !c && !w) return b0 ? 2 : 1;
        if (!r && !c) return 3;
        if (!r && !w) return 10;
        if (!r) return 6;
        if (!c && !w) return 8;
        if (!c) return 7;
        return 9;
    endfunction

    task automatic step(input bit cp, input bit ck, input bit cs, input bit r, input bit c,
                        input bit w, input bit [1:0] bv, input bit av, input string tag);
        int idx;
        bit v, tgt, e_ap;
        bit [3:0] nopen;
        cke_prev = cp; cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = bv; a10 = av;
        cur_cke = ck;
        idx = exp_code(cp, ck, cs, r, c, w, bv[0], m_pwr == 3);
        tgt = m_open[bv];
        v = 1'b0;
        if (m_mrs > 0 && idx != 0) v = 1'b1;
        if ((idx == 1 || idx == 2 || idx == 3 || idx == 4) && m_open != 0) v = 1'b1;
        if (idx == 6 && tgt) v = 1'b1;
        if ((idx == 7 || idx == 8) && (!tgt || m_wap > 0)) v = 1'b1;
        if (idx == 13) v = 1'b1;
        nopen = m_open;
        if (m_wap == 1) nopen[m_wapb] = 1'b0;
        if (m_mrs > 0) m_mrs--;
        if (m_wap > 0) m_wap--;
        if (!v) begin
            case (idx)
                1, 2: m_mrs = GAP;
                4: m_pwr = 3;
                11: m_pwr = (m_open != 0) ? 2 : 1;
                5, 12: m_pwr = 0;
                6: nopen[bv] = 1'b1;
                7: if (av) nopen[bv] = 1'b0;
                8: if (av) begin m_wap = BL / 2; m_wapb = bv; end
                10: if (av) nopen = 4'd0; else nopen[bv] = 1'b0;
                default: ;
            endcase
        end
        m_open = nopen;
        e_ap = av && (idx == 7 || idx == 8 || idx == 10);
        @(negedge clk);
        chk(tag, "cmd", cmd_o, 1 << idx);
        chk(tag, "bank", bank_o, bv);
        chk(tag, "ap", ap_o, e_ap);
        chk(tag, "viol", viol_o, v);
        chk(tag, "open", open_o, m_open);
        chk(tag, "pwr", pwr_o, m_pwr);
    endtask

    // shorthand for commands with clock enable high on both cycles
    task automatic cmd(input bit [2:0] rcw, input bit [1:0] bv, input bit av, input string tag);
        step(1'b1, 1'b1, 1'b0, rcw[2], rcw[1], rcw[0], bv, av, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        chk("R13", "cmd", cmd_o, 1);
        chk("R13", "viol", viol_o, 0);
        chk("R13", "open", open_o, 0);
        chk("R13", "pwr", pwr_o, 0);
        rst_n = 1'b1;

        step(1, 1, 1, 0, 0, 0, 2'd0, 0, "R2");   // deselect
        cmd(3'b111, 2'd1, 0, "R2");              // strobes all high
        cmd(3'b000, 2'd0, 0, "R1");              // mode write
        cmd(3'b111, 2'd0, 0, "R9");
        cmd(3'b111, 2'd0, 0, "R9");
        cmd(3'b001, 2'd0, 0, "R1");              // refresh right after the gap
        cmd(3'b000, 2'd1, 0, "R3");              // extended mode write
        cmd(3'b011, 2'd2, 0, "R9");              // too soon
        cmd(3'b111, 2'd0, 0, "R12");
        cmd(3'b011, 2'd2, 0, "R5");
        cmd(3'b011, 2'd2, 0, "R10");             // already open
        cmd(3'b001, 2'd0, 0, "R8");              // refresh with open bank
        cmd(3'b000, 2'd0, 0, "R8");
        cmd(3'b101, 2'd1, 0, "R10");             // read closed bank
        cmd(3'b011, 2'd1, 0, "R5");
        cmd(3'b101, 2'd1, 1, "R6");              // read + auto precharge
        cmd(3'b100, 2'd2, 1, "R7");              // write + auto precharge
        cmd(3'b101, 2'd2, 0, "R7");
        cmd(3'b100, 2'd2, 0, "R7");
        cmd(3'b101, 2'd2, 0, "R7");              // bank now closed
        cmd(3'b011, 2'd0, 0, "R5");
        cmd(3'b011, 2'd3, 0, "R5");
        cmd(3'b010, 2'd0, 0, "R5");              // single precharge
        cmd(3'b110, 2'd3, 0, "R1");              // burst stop
        cmd(3'b010, 2'd1, 1, "R5");              // all banks, bank bits ignored
        step(1, 0, 0, 1, 1, 1, 2'd0, 0, "R4");   // precharge power-down
        step(0, 0, 0, 0, 1, 1, 2'd2, 0, "R2");   // pins ignored
        step(0, 1, 1, 1, 1, 1, 2'd0, 0, "R4");
        cmd(3'b011, 2'd3, 0, "R5");
        step(1, 0, 1, 1, 1, 1, 2'd0, 0, "R4");   // active power-down
        step(0, 1, 1, 1, 1, 1, 2'd0, 0, "R4");
        cmd(3'b010, 2'd0, 1, "R5");
        step(1, 0, 0, 0, 0, 1, 2'd0, 0, "R4");   // self refresh entry
        step(0, 0, 1, 1, 1, 1, 2'd0, 0, "R4");
        step(0, 1, 1, 1, 1, 1, 2'd0, 0, "R4");   // self refresh exit
        step(1, 0, 0, 0, 1, 1, 2'd1, 0, "R11");  // cke falls with activate
        step(0, 1, 1, 1, 1, 1, 2'd0, 0, "R12");  // exit, flag gone
        cmd(3'b111, 2'd0, 0, "R12");

        for (int i = 0; i < 3000; i++) begin
            bit cp, ck, cs, av;
            bit [2:0] rcw;
            bit [1:0] bv;
            int sel;
            cp = cur_cke;
            if (cur_cke) ck = ($urandom % 12) != 0;
            else         ck = ($urandom % 3) == 0;
            cs = ($urandom % 8) == 0;
            sel = $urandom % 16;
            case (sel)
                0, 1, 2:  rcw = 3'b011;
                3, 4:     rcw = 3'b101;
                5, 6:     rcw = 3'b100;
                7, 8, 9:  rcw = 3'b010;
                10:       rcw = 3'b000;
                11:       rcw = 3'b001;
                12:       rcw = 3'b110;
                default:  rcw = 3'b111;
            endcase
            bv = 2'($urandom);
            av = ($urandom % 3) == 0;
            step(cp, ck, cs, rcw[2], rcw[1], rcw[0], bv, av, "R12");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule